// File: doc/BRIEF.md
# GF(2^233) Karatsuba Field Multiplier

This block multiplies two elements of the binary field GF(2^233) in polynomial basis. It returns the product fully reduced by the trinomial z^233 + z^74 + 1. Each operand is zero-padded to four 64-bit words, and the words are paired into a low and a high 128-bit digit. One Karatsuba step over the two digits calls for three 128x128 carry-less products. Each of those is split again by Karatsuba into three 64x64 carry-less products. All nine 64x64 products come from one combinational carry-less core, one product per cycle. Each product is XORed into a 512-bit accumulator at offsets that are whole multiples of 64 bits.

The sequencer has four states.
- IDLE waits for `start`. On start it captures both operands, clears the accumulator and moves to MUL.
- MUL runs the nine core products. The digit selector takes the order low, high, sum, and the word selector takes the same order inside each digit. After the ninth step MUL moves to FOLD_A.
- FOLD_A folds every coefficient at degree 233+i back onto degrees i and i+74, writes the result back to the accumulator, and moves to FOLD_B.
- FOLD_B runs the same fold a second time, registers the reduced product, raises `done` for one cycle and returns to IDLE.

While the sequencer is outside IDLE, `start` is ignored.

Top module: `gf233_kara_mul`

## Requirements
- R1: While reset is asserted, and after it is released, `done` is low and `prod` is zero until the first operation completes.
- R2: For operands whose bit i is the coefficient of z^i, `prod` equals opnd_a·opnd_b reduced modulo z^233 + z^74 + 1.
- R3: `done` is high for exactly one cycle. It rises at the 11th rising clock edge after the edge that accepts `start` in IDLE.
- R4: A `start` seen outside IDLE is ignored. The captured operands do not change, and the ignored start produces no completion.
- R5: `prod` keeps its value from one completion until the next.
- R6: If either operand is zero the product is zero. If either operand is 1 the product equals the other operand.
- R7: The unreduced product never sets a bit at position 465 or above. Two fold passes clear every bit at position 233 or above, including for the top-degree case z^232·z^232.
- R8: A `start` given in the cycle where `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiplication; sampled only in IDLE |
| opnd_a | input | 233 | First operand, bit i = coefficient of z^i |
| opnd_b | input | 233 | Second operand, same encoding |
| done | output | 1 | One-cycle pulse when `prod` holds a new result |
| prod | output | 233 | Reduced product, held until the next completion |

## Verification
The span assertion relies on the operand ports being exactly 233 bits wide, which keeps each operand's degree at 232 or less. The operand-hold assertion takes for granted that `start` can arrive on any cycle. The stimulus therefore raises `start` with unrelated operand values in the middle of busy windows, and also in the very cycle that `done` is high. Operands include zero, one, all ones and single high-degree terms, so the worst-case degree reaches both fold passes.

// File: rtl/gf233_kara_pkg.sv
package gf233_kara_pkg;

    // Sequencer states of the multiplier
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MUL    = 2'd1,
        ST_FOLD_A = 2'd2,
        ST_FOLD_B = 2'd3
    } kmul_state_e;

    // Selector codes shared by operand selection and product placement
    localparam logic [1:0] SEL_LO  = 2'd0;
    localparam logic [1:0] SEL_HI  = 2'd1;
    localparam logic [1:0] SEL_SUM = 2'd2;

endpackage

// File: rtl/cl_mul_core.sv
// Combinational W x W carry-less multiplier.
module cl_mul_core #(
    parameter int W = 64
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] p
);
    localparam int PW = 2 * W;

    logic [PW-1:0] x_ext;

    always_comb begin
        x_ext = {{W{1'b0}}, x};
        p     = '0;
        for (int i = 0; i < W; i++) begin
            if (y[i]) begin
                p = p ^ (x_ext << i);
            end
        end
    end

endmodule

// File: rtl/kara_opsel.sv
// Picks the 64-bit word pair for the current Karatsuba step.
module kara_opsel
    import gf233_kara_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [1:0][4*W-1:0] op,
    input  logic [1:0]          d_sel,
    input  logic [1:0]          k_sel,
    output logic [1:0][W-1:0]   word
);
    localparam int DW = 2 * W;

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        logic [DW-1:0] dig;

        always_comb begin
            case (d_sel)
                SEL_LO:  dig = op[g][DW-1:0];
                SEL_HI:  dig = op[g][2*DW-1:DW];
                default: dig = op[g][DW-1:0] ^ op[g][2*DW-1:DW];
            endcase
            case (k_sel)
                SEL_LO:  word[g] = dig[W-1:0];
                SEL_HI:  word[g] = dig[DW-1:W];
                default: word[g] = dig[W-1:0] ^ dig[DW-1:W];
            endcase
        end
    end

endmodule

// File: rtl/kara_place.sv
// Spreads one core product over the positions both Karatsuba levels assign it.
module kara_place
    import gf233_kara_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [2*W-1:0] q,
    input  logic [1:0]     d_sel,
    input  logic [1:0]     k_sel,
    output logic [8*W-1:0] contrib
);
    localparam int IW = 4 * W;
    localparam int OW = 8 * W;

    logic [IW-1:0] qx;
    logic [IW-1:0] inner;
    logic [OW-1:0] ix;

    always_comb begin
        qx = {{(2*W){1'b0}}, q};
        // inner level: low word product lands at 0 and W, high at 2W and W,
        // middle term at W only
        case (k_sel)
            SEL_LO:  inner = qx ^ (qx << W);
            SEL_HI:  inner = (qx << (2*W)) ^ (qx << W);
            default: inner = qx << W;
        endcase
        ix = {{IW{1'b0}}, inner};
        // outer level: same pattern with 128-bit digits
        case (d_sel)
            SEL_LO:  contrib = ix ^ (ix << (2*W));
            SEL_HI:  contrib = (ix << (4*W)) ^ (ix << (2*W));
            default: contrib = ix << (2*W);
        endcase
    end

endmodule

// File: rtl/trin_fold.sv
// One folding pass for the trinomial z^M + z^K + 1:
// every coefficient at M+i is added onto i and i+K.
module trin_fold #(
    parameter int M  = 233,
    parameter int K  = 74,
    parameter int AW = 2 * M - 1
) (
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout
);
    localparam int HW = AW - M;

    logic [HW-1:0] hi;
    logic [AW-1:0] lo_ext;
    logic [AW-1:0] hi_ext;

    always_comb begin
        hi     = din[AW-1:M];
        lo_ext = {{HW{1'b0}}, din[M-1:0]};
        hi_ext = {{M{1'b0}}, hi};
        dout   = lo_ext ^ hi_ext ^ (hi_ext << K);
    end

endmodule

// File: rtl/gf233_kara_mul.sv
module gf233_kara_mul
    import gf233_kara_pkg::*;
#(
    parameter int M = 233,
    parameter int K = 74,
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] opnd_a,
    input  logic [M-1:0] opnd_b,
    output logic         done,
    output logic [M-1:0] prod
);
    localparam int OPW  = 4 * W;        // padded operand width (two digits)
    localparam int ACCW = 2 * OPW;      // accumulator width
    localparam int AW   = 2 * M - 1;    // width of an unreduced product
    localparam int PADW = OPW - M;

    kmul_state_e state_q, state_d;

    logic [1:0][OPW-1:0] ops_q;
    logic [1:0]          d_q, k_q;
    logic [ACCW-1:0]     acc_q;
    logic                done_q;
    logic [M-1:0]        prod_q;

    logic [1:0][W-1:0]   words;
    logic [2*W-1:0]      core_p;
    logic [ACCW-1:0]     contrib;
    logic [AW-1:0]       fold_out;
    logic                last_step;

    assign last_step = (d_q == SEL_SUM) && (k_q == SEL_SUM);

    kara_opsel #(.W(W)) u_sel (
        .op    (ops_q),
        .d_sel (d_q),
        .k_sel (k_q),
        .word  (words)
    );

    cl_mul_core #(.W(W)) u_core (
        .x (words[0]),
        .y (words[1]),
        .p (core_p)
    );

    kara_place #(.W(W)) u_place (
        .q       (core_p),
        .d_sel   (d_q),
        .k_sel   (k_q),
        .contrib (contrib)
    );

    trin_fold #(.M(M), .K(K), .AW(AW)) u_fold (
        .din  (acc_q[AW-1:0]),
        .dout (fold_out)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_MUL;
            ST_MUL:    if (last_step) state_d = ST_FOLD_A;
            ST_FOLD_A: state_d = ST_FOLD_B;
            ST_FOLD_B: state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ops_q <= '0;
            d_q   <= SEL_LO;
            k_q   <= SEL_LO;
            acc_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ops_q[0] <= {{PADW{1'b0}}, opnd_a};
                        ops_q[1] <= {{PADW{1'b0}}, opnd_b};
                        acc_q    <= '0;
                        d_q      <= SEL_LO;
                        k_q      <= SEL_LO;
                    end
                end
                ST_MUL: begin
                    acc_q <= acc_q ^ contrib;
                    if (k_q == SEL_SUM) begin
                        k_q <= SEL_LO;
                        d_q <= d_q + 2'd1;
                    end else begin
                        k_q <= k_q + 2'd1;
                    end
                end
                ST_FOLD_A: begin
                    acc_q <= {{(ACCW-AW){1'b0}}, fold_out};
                end
                ST_FOLD_B: begin
                    acc_q <= acc_q;
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            prod_q <= '0;
        end else begin
            done_q <= (state_q == ST_FOLD_B);
            if (state_q == ST_FOLD_B) begin
                prod_q <= fold_out[M-1:0];
            end
        end
    end

    assign done = done_q;
    assign prod = prod_q;

    // ---------------- assertions ----------------
    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(ops_q));

    // R7
    acc_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FOLD_A) |-> (acc_q[ACCW-1:AW] == '0));

    // R7
    fold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FOLD_B) |-> (fold_out[AW-1:M] == '0));

    // R2
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL) |-> ((d_q != 2'd3) && (k_q != 2'd3)));

endmodule

// File: tb/test_gf233_kara_mul.sv
`timescale 1ns/1ps
module test_gf233_kara_mul;
    localparam int M   = 233;
    localparam int K   = 74;
    localparam int LAT = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] a_in = '0;
    logic [M-1:0] b_in = '0;
    logic         done;
    logic [M-1:0] prod;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int hold_err = 0;
    bit finished = 1'b0;

    logic [M-1:0] exp_q[$];
    int           iss_q[$];
    string        tag_q[$];

    logic [M-1:0] last_prod = '0;
    bit           have_last = 1'b0;
    logic         prev_done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    gf233_kara_mul i_gf233_kara_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .opnd_a (a_in),
        .opnd_b (b_in),
        .done   (done),
        .prod   (prod)
    );

    // bit-serial reference: shift-and-add with trinomial reduction
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r;
        logic         top;
        r = '0;
        for (int i = M - 1; i >= 0; i--) begin
            top = r[M-1];
            r   = r << 1;
            if (top) begin
                r[0] = ~r[0];
                r[K] = ~r[K];
            end
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [M-1:0] rand_elem();
        logic [255:0] t;
        for (int i = 0; i < 8; i++) t[i*32 +: 32] = $urandom;
        return t[M-1:0];
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // driver: called at a falling edge, returns at the falling edge where done is high
    task automatic do_op(input logic [M-1:0] a, input logic [M-1:0] b,
                         input bit noise, input string tag);
        a_in  = a;
        b_in  = b;
        start = 1'b1;
        exp_q.push_back(ref_mul(a, b));
        iss_q.push_back(cyc + 1);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        if (noise) begin
            repeat (2) @(negedge clk);
            a_in  = rand_elem();
            b_in  = rand_elem();
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done && prev_done) begin
                n_chk++; n_fail++;
                $display("FAIL R3: done high two cycles, actual 1 expected 0");
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R4: unexpected completion, actual prod %h expected no done", prod);
                end else begin
                    logic [M-1:0] e;
                    int           iss;
                    string        tg;
                    e   = exp_q.pop_front();
                    iss = iss_q.pop_front();
                    tg  = tag_q.pop_front();
                    n_chk++;
                    if (prod !== e) begin
                        n_fail++;
                        $display("FAIL %s: product actual %h expected %h", tg, prod, e);
                    end
                    n_chk++;
                    if (cyc != iss + LAT) begin
                        n_fail++;
                        $display("FAIL R3: done cycle actual %0d expected %0d", cyc, iss + LAT);
                    end
                    last_prod = prod;
                    have_last = 1'b1;
                end
            end else if (have_last && prod !== last_prod) begin
                hold_err++;
                if (hold_err == 1)
                    $display("FAIL R5: prod changed without done, actual %h expected %h", prod, last_prod);
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        logic [M-1:0] ones, z232, z1, r, r2;
        ones = '1;
        z232 = '0; z232[M-1] = 1'b1;
        z1   = '0; z1[1] = 1'b1;

        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if (done !== 1'b0) begin n_fail++; $display("FAIL R1: done in reset actual %b expected 0", done); end
        n_chk++;
        if (prod !== '0) begin n_fail++; $display("FAIL R1: prod in reset actual %h expected 0", prod); end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        n_chk++;
        if (done !== 1'b0 || prod !== '0) begin
            n_fail++; $display("FAIL R1: after reset actual done %b prod %h expected 0 0", done, prod);
        end

        // R6 corner operands
        r = rand_elem();
        do_op('0, r, 1'b0, "R6");
        @(negedge clk);
        do_op(r, '0, 1'b0, "R6");
        @(negedge clk);
        do_op({{(M-1){1'b0}}, 1'b1}, r, 1'b0, "R6");
        @(negedge clk);
        do_op(r, {{(M-1){1'b0}}, 1'b1}, 1'b0, "R6");
        @(negedge clk);
        // R2 / R7 high-degree corners
        do_op(ones, ones, 1'b0, "R2");
        @(negedge clk);
        do_op(z232, z232, 1'b0, "R7");
        @(negedge clk);
        do_op(z232, z1, 1'b0, "R7");
        @(negedge clk);
        // R4: stray starts while busy
        for (int i = 0; i < 3; i++) begin
            r = rand_elem(); r2 = rand_elem();
            do_op(r, r2, 1'b1, "R4");
            @(negedge clk);
        end
        // R2 / R8: random operands, some back to back
        for (int i = 0; i < 24; i++) begin
            int gap;
            gap = $urandom_range(0, 3);
            r = rand_elem(); r2 = rand_elem();
            do_op(r, r2, 1'b0, (gap == 0) ? "R8" : "R2");
            repeat (gap) @(negedge clk);
        end

        repeat (20) @(negedge clk);
        // R4: nothing left pending, no stray completion
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++; $display("FAIL R4: pending ops actual %0d expected 0", exp_q.size());
        end
        // R5: product held between completions
        n_chk++;
        if (hold_err != 0) begin
            n_fail++; $display("FAIL R5: hold violations actual %0d expected 0", hold_err);
        end
        finished = 1'b1;
        report();
        $finish;
    end

endmodule